// File: doc/BRIEF.md
# Branch target and condition unit

This block is the next-PC stage of an 8-bit microcontroller core. The decoder supplies an opcode class and the operands of a control-transfer instruction. The block then decides whether the transfer happens and which address follows. A transfer target can be one of four kinds:

- a signed 8-bit displacement from the following instruction's address;
- a full 16-bit address;
- an 11-bit address within the current 2 KiB page;
- an index formed from the 16-bit data pointer plus the accumulator.

The block also works out the side results of three instructions:

- the new carry from compare-and-jump;
- the decremented counter from decrement-and-jump;
- the bit clear from jump-if-bit-set-and-clear.

It also forms the code-table address for a table read relative to the PC. It picks the cycle cost from two supplied values, according to whether the transfer is taken. The caller adds that cost to its clock counter.

All results are registered, so they appear one clock after the operands are applied. Instruction fetch, memory, and the write-back of carry, counter and bit stay with the core.

Top module: `btc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every output is zero after that edge.
- R2: Each result is registered and due one clock after its operands. `cost_out` equals `cost_hit` when the transfer is taken and `cost_miss` otherwise. The `op` codes are: 0 sequential, 1 short relative jump, 2 long jump, 3 in-page jump, 4 indexed jump, 5 jump-if-carry, 6 jump-if-no-carry, 7 jump-if-bit, 8 jump-if-not-bit, 9 jump-if-bit-and-clear, 10 jump-if-A-zero, 11 jump-if-A-nonzero, 12 compare-and-jump, 13 decrement-and-jump, 14 PC-relative table read. Code 15 acts as 0.
- R3: A relative target is `next_pc` plus the sign-extended `rel_off`, modulo 2^16. Every conditional code (5 to 13) and code 1 use it. Code 1 is always taken.
- R4: Code 2 is always taken and its target is `abs_addr`.
- R5: Code 3 is always taken. Its target keeps bits 15:11 of `next_pc` and takes bits 10:0 of `abs_addr`.
- R6: Code 4 is always taken and its target is `dptr` plus zero-extended `acc`, modulo 2^16.
- R7: Code 5 is taken when `cy_in` is 1, and code 6 when it is 0. Code 7 is taken when `bit_in` is 1, and code 8 when it is 0. Code 10 is taken when `acc` is zero, and code 11 when it is not.
- R8: Code 9 is taken exactly when `bit_in` is 1. `bit_clr` is 1 only for code 9 with `bit_in` 1.
- R9: Code 12 is taken when `cmp_a` differs from `cmp_b`. For code 12, `cy_out` is 1 exactly when `cmp_a < cmp_b` unsigned. For every other code, `cy_out` equals `cy_in`.
- R10: For code 13, `cnt_out` is `cnt_in - 1` modulo 256, and the transfer is taken when that value is not zero. For other codes, `cnt_out` equals `cnt_in`.
- R11: `tbl_addr` is `next_pc` plus zero-extended `acc`, modulo 2^16. Code 14 is never taken and leaves the PC at `next_pc`.
- R12: Whenever the transfer is not taken, `pc_out` equals `next_pc`. This covers code 0, where `rel_off` and the flags have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Opcode class, codes as in R2 |
| next_pc | input | 16 | Address of the following instruction |
| rel_off | input | 8 | Signed relative displacement |
| abs_addr | input | 16 | Absolute operand (11 low bits used by the in-page jump) |
| acc | input | 8 | Accumulator |
| dptr | input | 16 | Data pointer |
| cy_in | input | 1 | Current carry flag |
| bit_in | input | 1 | Value of the tested bit |
| cmp_a | input | 8 | First compare operand |
| cmp_b | input | 8 | Second compare operand |
| cnt_in | input | 8 | Loop counter before decrement |
| cost_hit | input | 4 | Cycle cost when taken |
| cost_miss | input | 4 | Cycle cost when not taken |
| pc_out | output | 16 | Next program counter |
| taken | output | 1 | Transfer taken |
| cost_out | output | 4 | Selected cycle cost |
| cy_out | output | 1 | Carry flag after the instruction |
| cnt_out | output | 8 | Counter value to write back |
| bit_clr | output | 1 | Tested bit must be cleared |
| tbl_addr | output | 16 | PC-relative code-table address |

## Verification
Every output of this block passes through exactly one register, so each result is due at the first rising edge after its operands are applied, and it stays there until the next edge. The bench drives operands on a falling edge and compares all outputs on the following falling edge. No comparison can then land on a stale or half-updated value. The clock-based properties use the same rule: they relate each output to the inputs of the previous cycle. They ignore the first cycle after reset, when no operands have been captured yet.

// File: rtl/btc_pkg.sv
package btc_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_SEQ  = 4'd0,
    OP_SJMP = 4'd1,
    OP_LJMP = 4'd2,
    OP_AJMP = 4'd3,
    OP_JIDX = 4'd4,
    OP_JC   = 4'd5,
    OP_JNC  = 4'd6,
    OP_JB   = 4'd7,
    OP_JNB  = 4'd8,
    OP_JBC  = 4'd9,
    OP_JZ   = 4'd10,
    OP_JNZ  = 4'd11,
    OP_CJNE = 4'd12,
    OP_DJNZ = 4'd13,
    OP_MOVC = 4'd14
  } btc_op_e;
endpackage

// File: rtl/btc_target.sv
// Target address generation for every transfer kind, plus the table address.
module btc_target
  import btc_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 11
) (
  input  btc_op_e           op,
  input  logic [PC_W-1:0]   next_pc,
  input  logic [DATA_W-1:0] rel_off,
  input  logic [PC_W-1:0]   abs_addr,
  input  logic [DATA_W-1:0] acc,
  input  logic [PC_W-1:0]   dptr,
  output logic [PC_W-1:0]   jump_tgt,
  output logic [PC_W-1:0]   tbl_addr
);
  localparam int EXT_W = PC_W - DATA_W;
  localparam int HI_W  = PC_W - PAGE_W;

  logic [PC_W-1:0] rel_ext;
  logic [PC_W-1:0] acc_ext;
  logic [PC_W-1:0] rel_tgt;
  logic [PC_W-1:0] page_tgt;
  logic [PC_W-1:0] idx_tgt;

  assign rel_ext  = {{EXT_W{rel_off[DATA_W-1]}}, rel_off};
  assign acc_ext  = {{EXT_W{1'b0}}, acc};
  assign rel_tgt  = next_pc + rel_ext;
  assign page_tgt = {next_pc[PC_W-1 -: HI_W], abs_addr[PAGE_W-1:0]};
  assign idx_tgt  = dptr + acc_ext;
  assign tbl_addr = next_pc + acc_ext;

  always_comb begin
    case (op)
      OP_LJMP: jump_tgt = abs_addr;
      OP_AJMP: jump_tgt = page_tgt;
      OP_JIDX: jump_tgt = idx_tgt;
      default: jump_tgt = rel_tgt;
    endcase
  end
endmodule

// File: rtl/btc_cond.sv
// Taken decision and the side results of compare, decrement and bit-clear jumps.
module btc_cond
  import btc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  btc_op_e           op,
  input  logic              cy_in,
  input  logic              bit_in,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] cmp_a,
  input  logic [DATA_W-1:0] cmp_b,
  input  logic [DATA_W-1:0] cnt_in,
  output logic              taken,
  output logic              cy_new,
  output logic [DATA_W-1:0] cnt_new,
  output logic              bit_clr
);
  logic [DATA_W-1:0] cnt_dec;
  logic              acc_zero;
  logic              differ;
  logic              lower;

  assign cnt_dec  = cnt_in - DATA_W'(1);
  assign acc_zero = (acc == '0);
  assign differ   = (cmp_a != cmp_b);
  assign lower    = (cmp_a < cmp_b);

  always_comb begin
    taken   = 1'b0;
    cy_new  = cy_in;
    cnt_new = cnt_in;
    bit_clr = 1'b0;
    case (op)
      OP_SJMP, OP_LJMP, OP_AJMP, OP_JIDX: taken = 1'b1;
      OP_JC:   taken = cy_in;
      OP_JNC:  taken = !cy_in;
      OP_JB:   taken = bit_in;
      OP_JNB:  taken = !bit_in;
      OP_JBC: begin
        taken   = bit_in;
        bit_clr = bit_in;
      end
      OP_JZ:   taken = acc_zero;
      OP_JNZ:  taken = !acc_zero;
      OP_CJNE: begin
        taken  = differ;
        cy_new = lower;
      end
      OP_DJNZ: begin
        cnt_new = cnt_dec;
        taken   = (cnt_dec != '0);
      end
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/btc_unit.sv
module btc_unit
  import btc_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 11,
  parameter int COST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op,
  input  logic [PC_W-1:0]   next_pc,
  input  logic [DATA_W-1:0] rel_off,
  input  logic [PC_W-1:0]   abs_addr,
  input  logic [DATA_W-1:0] acc,
  input  logic [PC_W-1:0]   dptr,
  input  logic              cy_in,
  input  logic              bit_in,
  input  logic [DATA_W-1:0] cmp_a,
  input  logic [DATA_W-1:0] cmp_b,
  input  logic [DATA_W-1:0] cnt_in,
  input  logic [COST_W-1:0] cost_hit,
  input  logic [COST_W-1:0] cost_miss,
  output logic [PC_W-1:0]   pc_out,
  output logic              taken,
  output logic [COST_W-1:0] cost_out,
  output logic              cy_out,
  output logic [DATA_W-1:0] cnt_out,
  output logic              bit_clr,
  output logic [PC_W-1:0]   tbl_addr
);
  btc_op_e           op_e;
  logic [PC_W-1:0]   jump_tgt;
  logic [PC_W-1:0]   tbl_c;
  logic              taken_c;
  logic              cy_c;
  logic [DATA_W-1:0] cnt_c;
  logic              clr_c;

  assign op_e = btc_op_e'(op);

  btc_target #(.PC_W(PC_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_target (
    .op(op_e), .next_pc(next_pc), .rel_off(rel_off), .abs_addr(abs_addr),
    .acc(acc), .dptr(dptr), .jump_tgt(jump_tgt), .tbl_addr(tbl_c)
  );

  btc_cond #(.DATA_W(DATA_W)) u_cond (
    .op(op_e), .cy_in(cy_in), .bit_in(bit_in), .acc(acc), .cmp_a(cmp_a),
    .cmp_b(cmp_b), .cnt_in(cnt_in), .taken(taken_c), .cy_new(cy_c),
    .cnt_new(cnt_c), .bit_clr(clr_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_out   <= '0;
      taken    <= 1'b0;
      cost_out <= '0;
      cy_out   <= 1'b0;
      cnt_out  <= '0;
      bit_clr  <= 1'b0;
      tbl_addr <= '0;
    end else begin
      pc_out   <= taken_c ? jump_tgt : next_pc;
      taken    <= taken_c;
      cost_out <= taken_c ? cost_hit : cost_miss;
      cy_out   <= cy_c;
      cnt_out  <= cnt_c;
      bit_clr  <= clr_c;
      tbl_addr <= tbl_c;
    end
  end
endmodule

// File: rtl/btc_chk.sv
module btc_chk
  import btc_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DATA_W = 8,
  parameter int COST_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [OP_W-1:0]   op,
  input logic [PC_W-1:0]   next_pc,
  input logic [DATA_W-1:0] cmp_a,
  input logic [DATA_W-1:0] cmp_b,
  input logic [COST_W-1:0] cost_hit,
  input logic [COST_W-1:0] cost_miss,
  input logic [PC_W-1:0]   pc_out,
  input logic              taken,
  input logic [COST_W-1:0] cost_out,
  input logic              bit_clr
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pc_out == '0 && !taken && !bit_clr && cost_out == '0));

  // R2
  cost_pick_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> cost_out == (taken ? $past(cost_hit) : $past(cost_miss)));

  // R12
  hold_pc_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !taken) |-> pc_out == $past(next_pc));

  // R8
  jbc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    bit_clr |-> (taken && $past(op) == OP_JBC));

  // R9
  cjne_taken_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(op) == OP_CJNE) |-> taken == ($past(cmp_a) != $past(cmp_b)));

  // R11
  movc_stay_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(op) == OP_MOVC) |-> !taken);
endmodule

bind btc_unit btc_chk #(.PC_W(PC_W), .DATA_W(DATA_W), .COST_W(COST_W)) i_btc_chk (
  .clk(clk), .rst(rst), .op(op), .next_pc(next_pc), .cmp_a(cmp_a), .cmp_b(cmp_b),
  .cost_hit(cost_hit), .cost_miss(cost_miss), .pc_out(pc_out), .taken(taken),
  .cost_out(cost_out), .bit_clr(bit_clr)
);

// File: tb/test_btc_unit.sv
`timescale 1ns/1ps
module test_btc_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  op;
  logic [15:0] next_pc, abs_addr, dptr;
  logic [7:0]  rel_off, acc, cmp_a, cmp_b, cnt_in;
  logic        cy_in, bit_in;
  logic [3:0]  cost_hit, cost_miss;
  logic [15:0] pc_out, tbl_addr;
  logic        taken, cy_out, bit_clr;
  logic [3:0]  cost_out;
  logic [7:0]  cnt_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  btc_unit i_btc_unit (
    .clk(clk), .rst(rst), .op(op), .next_pc(next_pc), .rel_off(rel_off),
    .abs_addr(abs_addr), .acc(acc), .dptr(dptr), .cy_in(cy_in), .bit_in(bit_in),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .cnt_in(cnt_in), .cost_hit(cost_hit),
    .cost_miss(cost_miss), .pc_out(pc_out), .taken(taken), .cost_out(cost_out),
    .cy_out(cy_out), .cnt_out(cnt_out), .bit_clr(bit_clr), .tbl_addr(tbl_addr)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [15:0] npc;
    logic [7:0]  off;
    logic [15:0] absa;
    logic [7:0]  acc;
    logic [15:0] dptr;
    logic        cy;
    logic        bt;
    logic [7:0]  ca;
    logic [7:0]  cb;
    logic [7:0]  cnt;
    logic [15:0] epc;
    logic        etk;
  } vec_t;

  function automatic vec_t mk(logic [3:0] o, logic [15:0] n, logic [7:0] f,
                              logic [15:0] a, logic [7:0] ac, logic [15:0] d,
                              logic c, logic b, logic [7:0] x, logic [7:0] y,
                              logic [7:0] k, logic [15:0] e, logic t);
    vec_t v;
    v.op = o; v.npc = n; v.off = f; v.absa = a; v.acc = ac; v.dptr = d;
    v.cy = c; v.bt = b; v.ca = x; v.cb = y; v.cnt = k; v.epc = e; v.etk = t;
    return v;
  endfunction

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    mk(4'd1,  16'h1000, 8'h10, 16'h0000, 8'h00, 16'h0000, 0, 0, 8'h00, 8'h00, 8'h00, 16'h1010, 1),
    mk(4'd1,  16'h1000, 8'hF0, 16'h0000, 8'h00, 16'h0000, 0, 0, 8'h00, 8'h00, 8'h00, 16'h0FF0, 1),
    mk(4'd1,  16'hFFFE, 8'h05, 16'h0000, 8'h00, 16'h0000, 0, 0, 8'h00, 8'h00, 8'h00, 16'h0003, 1),
    mk(4'd2,  16'h1234, 8'h00, 16'hBEEF, 8'h00, 16'h0000, 0, 0, 8'h00, 8'h00, 8'h00, 16'hBEEF, 1),
    mk(4'd3,  16'hA7FF, 8'h00, 16'hF923, 8'h00, 16'h0000, 0, 0, 8'h00, 8'h00, 8'h00, 16'hA123, 1),
    mk(4'd4,  16'h5555, 8'h00, 16'h0000, 8'h20, 16'hFFF0, 0, 0, 8'h00, 8'h00, 8'h00, 16'h0010, 1),
    mk(4'd5,  16'h0200, 8'h08, 16'h0000, 8'h00, 16'h0000, 1, 0, 8'h00, 8'h00, 8'h00, 16'h0208, 1),
    mk(4'd5,  16'h0200, 8'h08, 16'h0000, 8'h00, 16'h0000, 0, 0, 8'h00, 8'h00, 8'h00, 16'h0200, 0),
    mk(4'd6,  16'h0200, 8'h08, 16'h0000, 8'h00, 16'h0000, 0, 0, 8'h00, 8'h00, 8'h00, 16'h0208, 1),
    mk(4'd6,  16'h0200, 8'h08, 16'h0000, 8'h00, 16'h0000, 1, 0, 8'h00, 8'h00, 8'h00, 16'h0200, 0),
    mk(4'd7,  16'h0300, 8'hFE, 16'h0000, 8'h00, 16'h0000, 0, 1, 8'h00, 8'h00, 8'h00, 16'h02FE, 1),
    mk(4'd7,  16'h0300, 8'hFE, 16'h0000, 8'h00, 16'h0000, 0, 0, 8'h00, 8'h00, 8'h00, 16'h0300, 0),
    mk(4'd8,  16'h0300, 8'hFE, 16'h0000, 8'h00, 16'h0000, 0, 0, 8'h00, 8'h00, 8'h00, 16'h02FE, 1),
    mk(4'd10, 16'h0400, 8'h7F, 16'h0000, 8'h00, 16'h0000, 0, 0, 8'h00, 8'h00, 8'h00, 16'h047F, 1),
    mk(4'd10, 16'h0400, 8'h7F, 16'h0000, 8'h01, 16'h0000, 0, 0, 8'h00, 8'h00, 8'h00, 16'h0400, 0),
    mk(4'd11, 16'h0400, 8'h80, 16'h0000, 8'h05, 16'h0000, 0, 0, 8'h00, 8'h00, 8'h00, 16'h0380, 1),
    mk(4'd11, 16'h0400, 8'h80, 16'h0000, 8'h00, 16'h0000, 0, 0, 8'h00, 8'h00, 8'h00, 16'h0400, 0),
    mk(4'd12, 16'h0500, 8'h04, 16'h0000, 8'h00, 16'h0000, 0, 0, 8'h03, 8'h03, 8'h00, 16'h0500, 0),
    mk(4'd12, 16'h0500, 8'h04, 16'h0000, 8'h00, 16'h0000, 0, 0, 8'h02, 8'h09, 8'h00, 16'h0504, 1),
    mk(4'd13, 16'h0600, 8'hFC, 16'h0000, 8'h00, 16'h0000, 0, 0, 8'h00, 8'h00, 8'h01, 16'h0600, 0),
    mk(4'd13, 16'h0600, 8'hFC, 16'h0000, 8'h00, 16'h0000, 0, 0, 8'h00, 8'h00, 8'h00, 16'h05FC, 1),
    mk(4'd14, 16'h3000, 8'h10, 16'h0000, 8'h80, 16'h0000, 0, 0, 8'h00, 8'h00, 8'h00, 16'h3000, 0),
    mk(4'd0,  16'h7777, 8'h10, 16'h0000, 8'h00, 16'h0000, 1, 1, 8'h00, 8'h00, 8'h00, 16'h7777, 0),
    mk(4'd9,  16'h0100, 8'h02, 16'h0000, 8'h00, 16'h0000, 0, 1, 8'h00, 8'h00, 8'h00, 16'h0102, 1)
  };

  function automatic string req_of(logic [3:0] o);
    case (o)
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3: return "R5";
      4'd4: return "R6";
      4'd5, 4'd6, 4'd7, 4'd8, 4'd10, 4'd11: return "R7";
      4'd9: return "R8";
      4'd12: return "R9";
      4'd13: return "R10";
      4'd14: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] o, logic [15:0] n, logic [7:0] f, logic [15:0] a,
                       logic [7:0] ac, logic [15:0] d, logic c, logic b,
                       logic [7:0] x, logic [7:0] y, logic [7:0] k);
    op = o; next_pc = n; rel_off = f; abs_addr = a; acc = ac; dptr = d;
    cy_in = c; bit_in = b; cmp_a = x; cmp_b = y; cnt_in = k;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    cost_hit = 4'd3;
    cost_miss = 4'd2;
    drive(4'd1, 16'h1234, 8'h11, 16'h0, 8'h0, 16'h0, 0, 0, 8'h0, 8'h0, 8'h0);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pc", pc_out, 16'h0);
    check("R1 taken", taken, 16'h0);
    check("R1 cost", cost_out, 16'h0);
    check("R1 tbl", tbl_addr, 16'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].op, TBL[i].npc, TBL[i].off, TBL[i].absa, TBL[i].acc, TBL[i].dptr,
            TBL[i].cy, TBL[i].bt, TBL[i].ca, TBL[i].cb, TBL[i].cnt);
      @(negedge clk);
      check(req_of(TBL[i].op), pc_out, TBL[i].epc);
      check(req_of(TBL[i].op), taken, TBL[i].etk);
      check("R2 cost", cost_out, TBL[i].etk ? 16'd3 : 16'd2);
    end

    // R9 carry from unsigned compare
    drive(4'd12, 16'h0, 8'h0, 16'h0, 8'h0, 16'h0, 0, 0, 8'h02, 8'h09, 8'h0);
    @(negedge clk); check("R9 cy lower", cy_out, 16'h1);
    drive(4'd12, 16'h0, 8'h0, 16'h0, 8'h0, 16'h0, 1, 0, 8'h90, 8'h20, 8'h0);
    @(negedge clk); check("R9 cy higher", cy_out, 16'h0);
    drive(4'd12, 16'h0, 8'h0, 16'h0, 8'h0, 16'h0, 1, 0, 8'h09, 8'h09, 8'h0);
    @(negedge clk); check("R9 cy equal", cy_out, 16'h0);
    drive(4'd5, 16'h0, 8'h0, 16'h0, 8'h0, 16'h0, 1, 0, 8'h00, 8'h09, 8'h0);
    @(negedge clk); check("R9 cy pass", cy_out, 16'h1);

    // R10 counter write-back
    drive(4'd13, 16'h0, 8'h0, 16'h0, 8'h0, 16'h0, 0, 0, 8'h0, 8'h0, 8'h00);
    @(negedge clk); check("R10 wrap", cnt_out, 16'h00FF);
    drive(4'd13, 16'h0, 8'h0, 16'h0, 8'h0, 16'h0, 0, 0, 8'h0, 8'h0, 8'h01);
    @(negedge clk); check("R10 to zero", cnt_out, 16'h0000);
    check("R10 zero not taken", taken, 16'h0);
    drive(4'd7, 16'h0, 8'h0, 16'h0, 8'h0, 16'h0, 0, 1, 8'h0, 8'h0, 8'h42);
    @(negedge clk); check("R10 unchanged", cnt_out, 16'h0042);

    // R8 bit clear only on jump-if-bit-and-clear with bit set
    drive(4'd9, 16'h0, 8'h0, 16'h0, 8'h0, 16'h0, 0, 1, 8'h0, 8'h0, 8'h0);
    @(negedge clk); check("R8 clr set", bit_clr, 16'h1);
    drive(4'd9, 16'h0, 8'h0, 16'h0, 8'h0, 16'h0, 0, 0, 8'h0, 8'h0, 8'h0);
    @(negedge clk); check("R8 clr idle", bit_clr, 16'h0);
    drive(4'd7, 16'h0, 8'h0, 16'h0, 8'h0, 16'h0, 0, 1, 8'h0, 8'h0, 8'h0);
    @(negedge clk); check("R8 clr other op", bit_clr, 16'h0);

    // R11 table address wraps
    drive(4'd14, 16'hFFC0, 8'h0, 16'h0, 8'h80, 16'h0, 0, 0, 8'h0, 8'h0, 8'h0);
    @(negedge clk); check("R11 tbl", tbl_addr, 16'h0040);
    check("R11 pc", pc_out, 16'hFFC0);

    // R1 reset in mid-run
    drive(4'd1, 16'h2000, 8'h22, 16'h0, 8'h0, 16'h0, 0, 0, 8'h0, 8'h0, 8'h0);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid pc", pc_out, 16'h0);
    check("R1 mid taken", taken, 16'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R3 after reset", pc_out, 16'h2022);

    finish_run();
  end
endmodule